// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block makes the hazard decisions for a five-stage in-order integer pipeline. The stages run in this order: fetch, decode with register read, execute or address calculation, data memory access, and register writeback. Each cycle the controller looks at the two source register numbers of the instruction in decode and compares them with the destinations of the instructions in execute and memory. It also sees whether the execute instruction is a load, whether the memory-stage instruction is using the single shared memory port, and whether a branch in execute has resolved as taken. The datapath, the ALU, the memory and the register storage are outside the block.

From these inputs the controller produces several control outputs. It drives a two-bit operand source select for each ALU input, and it computes that select while the consumer is still in decode, then registers it so the select is ready when the consumer enters execute. It also drives hold enables for the PC and the fetch/decode latch, a clear for the execute latch (a bubble), and a flush of the fetch/decode latch. Branches are predicted not taken. A taken branch discards the two younger instructions, and fetch then redirects to the target. Because the register file is written in the first half of a cycle and read in the second half, a producer that has reached writeback needs no path to a consumer in decode.

Top module: `hzc_pipe_ctrl`

## Requirements
- R1: When a decode source equals the nonzero destination of a writing, non-load instruction in execute, that operand's select reads 01 (memory-stage ALU result) in the next cycle, and no hold or bubble is raised.
- R2: When a decode source equals the nonzero destination of a writing instruction in the memory stage, with no execute match, the select reads 10 (writeback-stage value) in the next cycle.
- R3: When both the execute and memory producers match the same source, the select reads 01 in the next cycle, because the younger producer wins.
- R4: A source of register 0, or a producer with its write enable low, never matches: the select reads 00 (register file) and no hold or bubble comes from it.
- R5: A load in execute whose nonzero destination equals either decode source raises the PC hold, the fetch/decode hold and the execute bubble in that same cycle, and both selects read 00 in the next cycle.
- R6: After the single bubble, the load sits in the memory stage. The waiting consumer then gets select 10 in the next cycle, and no second bubble is raised.
- R7: A taken branch raises the fetch/decode flush and the execute bubble, and it drops both holds even when a load-use hazard is present at the same time. The selects read 00 in the next cycle.
- R8: A memory-stage instruction that uses the memory port raises the PC and fetch/decode holds without a bubble. The forwarding selects are still updated.
- R9: A taken branch while the memory port is busy raises no hold, so the PC can take the branch target.
- R10: A synchronous active-high reset sets both forwarding selects to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| id_rs1_i | input | 5 | First source register of the decode instruction |
| id_rs2_i | input | 5 | Second source register of the decode instruction |
| ex_rd_i | input | 5 | Destination register of the execute instruction |
| ex_wen_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | 5 | Destination register of the memory-stage instruction |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| mem_memuse_i | input | 1 | Memory-stage instruction uses the shared memory port |
| br_taken_i | input | 1 | Branch in execute resolved as taken |
| fwd_a_o | output | 2 | First ALU operand source select (00 regfile, 01 memory stage, 10 writeback) |
| fwd_b_o | output | 2 | Second ALU operand source select, same encoding |
| pc_hold_o | output | 1 | Hold the PC |
| ifid_hold_o | output | 1 | Hold the fetch/decode latch |
| ex_bubble_o | output | 1 | Clear the execute latch control word |
| ifid_flush_o | output | 1 | Discard the fetch/decode latch contents |

## Verification
The hardest situation to reach is the load-use sequence followed through two cycles. First the load in execute must force exactly one bubble. One cycle later the same consumer is still in decode, while the load now sits in the memory stage and also occupies the memory port. At that point the consumer must receive the writeback-stage select, and a fetch hold must appear but no second bubble. The stimulus table places these two vectors back to back, with the decode sources unchanged and the load's destination moved from the execute fields to the memory fields. The same table also sets up a taken branch during a load-use match, and a taken branch during a busy memory port, to check the override order.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_MEMSTG  = 2'b01,
    SEL_WBSTG   = 2'b10
  } fwd_sel_t;

  localparam int unsigned NUM_OPS = 2;
endpackage

// File: rtl/hzc_match.sv
module hzc_match #(
  parameter int unsigned RW = 5
) (
  input  logic [RW-1:0] src_i,
  input  logic [RW-1:0] dst_i,
  input  logic          wen_i,
  output logic          hit_o
);
  // register 0 is never a producer: its writes are dropped
  assign hit_o = wen_i && (dst_i != '0) && (src_i == dst_i);
endmodule

// File: rtl/hzc_fwd_reg.sv
module hzc_fwd_reg
  import hzc_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [RW-1:0] src_i,
  input  logic          hit_young_i,
  input  logic          hit_old_i,
  input  logic          clear_i,
  output fwd_sel_t      sel_o
);
  fwd_sel_t sel_nxt;

  always_comb begin
    if (clear_i)          sel_nxt = SEL_REGFILE;
    else if (hit_young_i) sel_nxt = SEL_MEMSTG;
    else if (hit_old_i)   sel_nxt = SEL_WBSTG;
    else                  sel_nxt = SEL_REGFILE;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) sel_o <= SEL_REGFILE;
    else       sel_o <= sel_nxt;
  end

  // R4
  zero_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (src_i == '0) |=> (sel_o == SEL_REGFILE));

  // R3
  young_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_young_i && !clear_i) |=> (sel_o == SEL_MEMSTG));
endmodule

// File: rtl/hzc_stall.sv
module hzc_stall (
  input  logic load_use_i,
  input  logic port_busy_i,
  input  logic taken_i,
  output logic pc_hold_o,
  output logic ifid_hold_o,
  output logic ex_bubble_o,
  output logic ifid_flush_o
);
  logic freeze;

  // a redirect wins over every reason to freeze the front end
  assign freeze       = !taken_i && (load_use_i || port_busy_i);
  assign pc_hold_o    = freeze;
  assign ifid_hold_o  = freeze;
  assign ex_bubble_o  = taken_i || load_use_i;
  assign ifid_flush_o = taken_i;
endmodule

// File: rtl/hzc_pipe_ctrl.sv
module hzc_pipe_ctrl
  import hzc_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [RW-1:0] id_rs1_i,
  input  logic [RW-1:0] id_rs2_i,
  input  logic [RW-1:0] ex_rd_i,
  input  logic          ex_wen_i,
  input  logic          ex_load_i,
  input  logic [RW-1:0] mem_rd_i,
  input  logic          mem_wen_i,
  input  logic          mem_memuse_i,
  input  logic          br_taken_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          pc_hold_o,
  output logic          ifid_hold_o,
  output logic          ex_bubble_o,
  output logic          ifid_flush_o
);
  logic [RW-1:0]      src [NUM_OPS];
  logic [NUM_OPS-1:0] hit_ex;
  logic [NUM_OPS-1:0] hit_mem;
  fwd_sel_t           sel [NUM_OPS];
  logic               load_use;

  assign src[0] = id_rs1_i;
  assign src[1] = id_rs2_i;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    hzc_match #(.RW(RW)) u_ex_cmp (
      .src_i (src[op]),
      .dst_i (ex_rd_i),
      .wen_i (ex_wen_i),
      .hit_o (hit_ex[op])
    );

    hzc_match #(.RW(RW)) u_mem_cmp (
      .src_i (src[op]),
      .dst_i (mem_rd_i),
      .wen_i (mem_wen_i),
      .hit_o (hit_mem[op])
    );

    hzc_fwd_reg #(.RW(RW)) u_sel (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .src_i       (src[op]),
      .hit_young_i (hit_ex[op]),
      .hit_old_i   (hit_mem[op]),
      .clear_i     (ex_bubble_o),
      .sel_o       (sel[op])
    );
  end

  assign load_use = ex_load_i && (|hit_ex);

  hzc_stall u_stall (
    .load_use_i   (load_use),
    .port_busy_i  (mem_memuse_i),
    .taken_i      (br_taken_i),
    .pc_hold_o    (pc_hold_o),
    .ifid_hold_o  (ifid_hold_o),
    .ex_bubble_o  (ex_bubble_o),
    .ifid_flush_o (ifid_flush_o)
  );

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  // R5
  load_use_stall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ex_load_i && ex_wen_i && ex_rd_i != '0 && id_rs1_i == ex_rd_i && !br_taken_i)
      |-> (pc_hold_o && ifid_hold_o && ex_bubble_o));

  // R5
  bubble_no_fwd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ex_bubble_o |=> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

  // R7
  flush_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    br_taken_i |-> (ifid_flush_o && ex_bubble_o && !pc_hold_o && !ifid_hold_o));

  // R8
  port_busy_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mem_memuse_i && !br_taken_i) |-> (pc_hold_o && ifid_hold_o));

  // R1
  alu_fwd_no_stall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ex_load_i && !br_taken_i && !mem_memuse_i) |-> (!pc_hold_o && !ex_bubble_o));
endmodule

// File: tb/test_hzc_pipe_ctrl.sv
`timescale 1ns/1ps
module test_hzc_pipe_ctrl;
  localparam int RW = 5;
  localparam int NV = 12;

  typedef struct packed {
    logic [4:0] s1;
    logic [4:0] s2;
    logic [4:0] exd;
    logic       exw;
    logic       exl;
    logic [4:0] md;
    logic       mw;
    logic       mm;
    logic       tk;
    logic       hold;
    logic       bub;
    logic       fl;
    logic [1:0] fa;
    logic [1:0] fb;
  } vec_t;

  // s1 s2 exd exw exl md mw mm tk | hold bub fl fa fb
  localparam vec_t VEC [NV] = '{
    '{5'd1, 5'd2, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{5'd3, 5'd2, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0},
    '{5'd1, 5'd4, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2},
    '{5'd7, 5'd7, 5'd7, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1},
    '{5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{5'd5, 5'd6, 5'd5, 1'b0, 1'b0, 5'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0},
    '{5'd8, 5'd1, 5'd8, 1'b1, 1'b1, 5'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0},
    '{5'd8, 5'd1, 5'd9, 1'b0, 1'b0, 5'd8, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 2'd0},
    '{5'd8, 5'd0, 5'd8, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0},
    '{5'd1, 5'd2, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0},
    '{5'd3, 5'd4, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd2},
    '{5'd6, 5'd9, 5'd9, 1'b1, 1'b1, 5'd6, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0}
  };

  localparam string TAG [NV] = '{
    "R4 base", "R1 alu fwd", "R2 mem fwd", "R3 priority", "R4 reg0", "R4 no wen",
    "R5 load-use", "R6 after bubble R8", "R7 flush over stall", "R9 flush port busy",
    "R8 port busy", "R5 load-use rs2"
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [RW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic          ex_wen, ex_load, mem_wen, mem_memuse, br_taken;
  logic [1:0]    fwd_a, fwd_b;
  logic          pc_hold, ifid_hold, ex_bubble, ifid_flush;
  int            total = 0;
  int            failed = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  hzc_pipe_ctrl #(.RW(RW)) i_hzc_pipe_ctrl (
    .clk_i        (clk),
    .rst_i        (rst),
    .id_rs1_i     (id_rs1),
    .id_rs2_i     (id_rs2),
    .ex_rd_i      (ex_rd),
    .ex_wen_i     (ex_wen),
    .ex_load_i    (ex_load),
    .mem_rd_i     (mem_rd),
    .mem_wen_i    (mem_wen),
    .mem_memuse_i (mem_memuse),
    .br_taken_i   (br_taken),
    .fwd_a_o      (fwd_a),
    .fwd_b_o      (fwd_b),
    .pc_hold_o    (pc_hold),
    .ifid_hold_o  (ifid_hold),
    .ex_bubble_o  (ex_bubble),
    .ifid_flush_o (ifid_flush)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    id_rs1 = v.s1; id_rs2 = v.s2;
    ex_rd = v.exd; ex_wen = v.exw; ex_load = v.exl;
    mem_rd = v.md; mem_wen = v.mw; mem_memuse = v.mm;
    br_taken = v.tk;
  endtask

  initial begin
    rst = 1'b1;
    apply(VEC[0]);
    repeat (3) @(posedge clk);
    #1;
    // R10: selects cleared by reset
    chk("R10 reset selects", {4'd0, fwd_a, fwd_b}, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      #1;
      chk({TAG[i], " ctl"}, {4'd0, pc_hold, ifid_hold, ex_bubble, ifid_flush},
          {4'd0, VEC[i].hold, VEC[i].hold, VEC[i].bub, VEC[i].fl});
      @(posedge clk);
      #1;
      chk({TAG[i], " sel"}, {4'd0, fwd_a, fwd_b}, {4'd0, VEC[i].fa, VEC[i].fb});
    end

    // R10: reset overrides a matching producer
    @(negedge clk);
    apply(VEC[3]);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 reset over match", {4'd0, fwd_a, fwd_b}, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    // R2: a mem-stage load feeds operand b through select 10
    @(negedge clk);
    id_rs1 = 5'd0; id_rs2 = 5'd12; ex_rd = 5'd13; ex_wen = 1'b1; ex_load = 1'b1;
    mem_rd = 5'd12; mem_wen = 1'b1; mem_memuse = 1'b1; br_taken = 1'b0;
    #1;
    chk("R8 busy no bubble", {4'd0, pc_hold, ifid_hold, ex_bubble, ifid_flush}, 8'h0c);
    @(posedge clk);
    #1;
    chk("R2 load result", {4'd0, fwd_a, fwd_b}, 8'h02);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      failed++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", total, failed);
      $finish;
    end
  end
endmodule